// File: doc/BRIEF.md
# Prioritized Event Interrupt Arbiter

This block watches seventeen level-sensitive event interrupt request lines and chooses the single source that should be presented to the processor. Each source has its own enable bit and a three-bit priority setting. A single global enable masks every source at once. A priority setting of zero turns the source off. Any nonzero setting n maps to an effective level of 8+n, so the live levels run from 9 to 15.

A request reaches the processor only when the winning level is strictly higher than the processor's current execution priority, which is a 4-bit input. When several active sources share the top level, the lowest-numbered source wins. The request flag, the winner's index and its effective level are registered. They therefore follow the sampled inputs by one clock.

Configuration goes through a small write port. Addresses 0 to 16 select a source, where data bit 3 is that source's enable and data bits 2:0 are its priority setting. Address 17 is the global control, where data bit 0 is the global enable. Writes to any higher address are ignored.

Top module: `irq_event_arbiter`

## Requirements
- R1: A synchronous active-high reset clears all enables, the global enable and all priority settings, and drives irq_req, irq_id and irq_level to 0. After reset, no source raises a request until it has been configured.
- R2: While the global enable (address 17, data bit 0) is clear, irq_req stays 0 whatever the request lines and source settings are.
- R3: A source whose enable bit (data bit 3 at its own address) is clear never wins the arbitration.
- R4: A source whose priority setting (data bits 2:0) is 0 never wins, even when it is enabled.
- R5: A winning source with setting n is reported on irq_level as 8+n, so irq_level is always in the range 9 to 15 while irq_req is 1.
- R6: Among the active sources (enabled, nonzero setting, request line high, global enable set), the one with the highest effective level wins.
- R7: When several active sources share the highest level, the one with the lowest index wins.
- R8: irq_req is 1 only when the winner's level is strictly greater than cpu_pri. Otherwise irq_req, irq_id and irq_level are all 0.
- R9: The outputs reflect the request lines and cpu_pri sampled at the previous rising edge. The outputs do not change between clock edges.
- R10: A write to an address above 17 changes no configuration state.
- R11: A configuration write accepted at one edge is used by the arbitration at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 17 | Level-sensitive event request lines, bit i is source i |
| cpu_pri | input | 4 | Current processor execution priority |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | 0 to 16 selects a source, 17 selects the global control |
| cfg_wdata | input | 4 | Source: bit 3 enable, bits 2:0 priority setting. Global: bit 0 enable |
| irq_req | output | 1 | Request to the processor |
| irq_id | output | 5 | Index of the winning source, 0 when there is no request |
| irq_level | output | 4 | Effective level of the winner, 0 when there is no request |

## Verification
A corrupted enable or priority bit appears at the ports one edge after the affected source's request line is sampled. It shows either as a wrong irq_id or irq_level, or as a request that is missing or spurious against cpu_pri. A broken widening of the priority setting shows as a level outside 9 to 15 or one that is off by the top bit. A broken tie-break shows only when two sources share a level, so the stimulus deliberately drives equal-level pairs. Stray writes to unused addresses are caught because the next arbitration still matches the unchanged configuration.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRI_BITS = 3;
  localparam int LVL_BITS = PRI_BITS + 1;

  // Zero stays zero (source off); nonzero n gets a set top bit, i.e. 8+n.
  function automatic logic [LVL_BITS-1:0] widen_level(input logic [PRI_BITS-1:0] setting);
    if (setting == '0) widen_level = '0;
    else               widen_level = {1'b1, setting};
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs import irq_arb_pkg::*; #(
  parameter int N_SRC  = 17,
  parameter int ADDR_W = $clog2(N_SRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [PRI_BITS:0]         cfg_wdata,
  output logic [N_SRC-1:0]          en_q,
  output logic [N_SRC*PRI_BITS-1:0] pri_q,
  output logic                      glb_en_q
);
  localparam logic [ADDR_W-1:0] GLB_ADDR = ADDR_W'(N_SRC);

  logic glb_hit;
  assign glb_hit = cfg_we && (cfg_addr == GLB_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          glb_en_q <= 1'b0;
    else if (glb_hit) glb_en_q <= cfg_wdata[0];
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic wr_hit;
    assign wr_hit = cfg_we && (cfg_addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i]                       <= 1'b0;
        pri_q[i*PRI_BITS +: PRI_BITS] <= '0;
      end else if (wr_hit) begin
        en_q[i]                       <= cfg_wdata[PRI_BITS];
        pri_q[i*PRI_BITS +: PRI_BITS] <= cfg_wdata[PRI_BITS-1:0];
      end
    end
  end

  logic bad_addr_wr;
  assign bad_addr_wr = cfg_we && (cfg_addr > GLB_ADDR);

  assert_bad_addr_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    bad_addr_wr |=> ($stable(en_q) && $stable(pri_q) && $stable(glb_en_q)));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (en_q == '0 && pri_q == '0 && !glb_en_q));
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map import irq_arb_pkg::*; #(
  parameter int N_SRC = 17
) (
  input  logic [N_SRC-1:0]          req_in,
  input  logic [N_SRC-1:0]          en_q,
  input  logic [N_SRC*PRI_BITS-1:0] pri_q,
  input  logic                      glb_en_q,
  output logic [N_SRC*LVL_BITS-1:0] eff_lvl
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_map
    logic live;
    assign live = glb_en_q && en_q[i] && req_in[i];
    assign eff_lvl[i*LVL_BITS +: LVL_BITS] =
      live ? widen_level(pri_q[i*PRI_BITS +: PRI_BITS]) : '0;
  end
endmodule

// File: rtl/irq_pick_max.sv
module irq_pick_max import irq_arb_pkg::*; #(
  parameter int N_SRC = 17,
  parameter int ID_W  = $clog2(N_SRC)
) (
  input  logic [N_SRC*LVL_BITS-1:0] eff_lvl,
  output logic [LVL_BITS-1:0]       best_lvl,
  output logic [ID_W-1:0]           best_id
);
  // Strict greater-than keeps the earliest index on ties.
  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (eff_lvl[i*LVL_BITS +: LVL_BITS] > best_lvl) begin
        best_lvl = eff_lvl[i*LVL_BITS +: LVL_BITS];
        best_id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_event_arbiter.sv
module irq_event_arbiter import irq_arb_pkg::*; #(
  parameter int N_SRC  = 17,
  parameter int ADDR_W = $clog2(N_SRC + 1),
  parameter int ID_W   = $clog2(N_SRC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SRC-1:0]    req_in,
  input  logic [LVL_BITS-1:0] cpu_pri,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [PRI_BITS:0]   cfg_wdata,
  output logic                irq_req,
  output logic [ID_W-1:0]     irq_id,
  output logic [LVL_BITS-1:0] irq_level
);
  logic [N_SRC-1:0]          en_q;
  logic [N_SRC*PRI_BITS-1:0] pri_q;
  logic                      glb_en_q;
  logic [N_SRC*LVL_BITS-1:0] eff_lvl;
  logic [LVL_BITS-1:0]       best_lvl;
  logic [ID_W-1:0]           best_id;
  logic                      fire;

  irq_cfg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en_q(en_q), .pri_q(pri_q), .glb_en_q(glb_en_q));

  irq_level_map #(.N_SRC(N_SRC)) u_map (
    .req_in(req_in), .en_q(en_q), .pri_q(pri_q), .glb_en_q(glb_en_q),
    .eff_lvl(eff_lvl));

  irq_pick_max #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pick (
    .eff_lvl(eff_lvl), .best_lvl(best_lvl), .best_id(best_id));

  assign fire = (best_lvl > cpu_pri);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_id    <= '0;
      irq_level <= '0;
    end else begin
      irq_req   <= fire;
      irq_id    <= fire ? best_id  : '0;
      irq_level <= fire ? best_lvl : '0;
    end
  end

  assert_idle_outputs_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_id == '0 && irq_level == '0));

  assert_above_cpu_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level > $past(cpu_pri)));

  assert_level_range_R5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level >= LVL_BITS'(9)));

  assert_global_gate_R2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(glb_en_q));

  assert_winner_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(en_q[best_id] && req_in[best_id]));

  assert_winner_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ($past(pri_q[best_id*PRI_BITS +: PRI_BITS]) != '0));

  assert_reset_outputs_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_req && irq_id == '0 && irq_level == '0));
endmodule

// File: tb/tb_irq_event_arbiter.sv
`timescale 1ns/1ps
module tb_irq_event_arbiter;
  localparam int N = 17;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] req_in;
  logic [3:0]   cpu_pri;
  logic         cfg_we;
  logic [4:0]   cfg_addr;
  logic [3:0]   cfg_wdata;
  logic         irq_req;
  logic [4:0]   irq_id;
  logic [3:0]   irq_level;

  irq_event_arbiter dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench copy of the configuration.
  bit       m_en [N];
  bit [2:0] m_pri [N];
  bit       m_glb;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < N) begin m_en[a] = d[3]; m_pri[a] = d[2:0]; end
    else if (a == N) m_glb = d[0];
  endtask

  // Expected outcome: scan levels from the top, first index found wins.
  task automatic expect_out(input logic [N-1:0] r, input logic [3:0] cp,
                            output bit e_req, output int e_id, output int e_lvl);
    e_req = 0; e_id = 0; e_lvl = 0;
    for (int lv = 15; lv >= 9 && !e_req; lv--) begin
      for (int i = 0; i < N && !e_req; i++) begin
        if (m_glb && m_en[i] && r[i] && m_pri[i] != 0 && (8 + m_pri[i]) == lv && lv > cp) begin
          e_req = 1; e_id = i; e_lvl = lv;
        end
      end
    end
  endtask

  task automatic step_check(input string req, input logic [N-1:0] r, input logic [3:0] cp);
    bit e_req; int e_id, e_lvl;
    req_in = r; cpu_pri = cp;
    @(negedge clk);
    expect_out(r, cp, e_req, e_id, e_lvl);
    chk({req, " irq_req"}, irq_req, e_req);
    chk({req, " irq_id"}, irq_id, e_id);
    chk({req, " irq_level"}, irq_level, e_lvl);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed1234));
    rst = 1; req_in = '1; cpu_pri = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pri[i] = 0; end
    m_glb = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the outputs.
    chk("R1 reset irq_req", irq_req, 0);
    chk("R1 reset irq_id", irq_id, 0);
    chk("R1 reset irq_level", irq_level, 0);
    rst = 0;
    step_check("R1 no request after reset", '1, 0);
    wr(5'd17, 4'h1);
    step_check("R1 enables cleared by reset", '1, 0);

    // R3/R4/R5: single source, enable and zero setting.
    wr(5'd4, 4'b0_111);
    step_check("R3 disabled source", 17'h10, 0);
    wr(5'd4, 4'b1_000);
    step_check("R4 zero setting", 17'h10, 0);
    wr(5'd4, 4'b1_001);
    step_check("R5 setting 1 gives 9", 17'h10, 0);
    wr(5'd4, 4'b1_111);
    step_check("R5 setting 7 gives 15", 17'h10, 0);

    // R6: higher level wins over lower index.
    wr(5'd1, 4'b1_010);
    step_check("R6 higher level wins", 17'h12, 0);
    // R7: tie goes to lower index.
    wr(5'd16, 4'b1_011); wr(5'd9, 4'b1_011);
    step_check("R7 tie lowest index", 17'h10200, 0);
    chk("R7 tie winner is 9", irq_id, 9);
    // R8: strict compare against cpu_pri.
    step_check("R8 equal to cpu_pri", 17'h00200, 4'd11);
    step_check("R8 one above cpu_pri", 17'h00200, 4'd10);
    step_check("R8 cpu_pri 15 blocks", 17'h1ffff, 4'd15);
    // R2: global enable clear.
    wr(5'd17, 4'h0);
    step_check("R2 global off", 17'h1ffff, 0);
    wr(5'd17, 4'h1);

    // R10: writes above 17 ignored.
    wr(5'd18, 4'hf); wr(5'd31, 4'h0);
    step_check("R10 stray writes ignored", 17'h1ffff, 0);

    // R9: outputs hold until the next edge, then follow new inputs.
    step_check("R9 baseline", 17'h00010, 0);
    req_in = 17'h0; #1;
    chk("R9 hold before edge irq_req", irq_req, 1);
    chk("R9 hold before edge irq_id", irq_id, 4);
    @(negedge clk);
    chk("R9 updated after edge", irq_req, 0);

    // R11: write at one edge, used at the next.
    req_in = 17'h00004; cpu_pri = 0;
    cfg_we = 1; cfg_addr = 5'd2; cfg_wdata = 4'b1_110;
    @(negedge clk);
    cfg_we = 0; m_en[2] = 1; m_pri[2] = 3'b110;
    chk("R11 not yet used at write edge", irq_req, 0);
    @(negedge clk);
    chk("R11 used at next edge", irq_level, 14);

    // Constrained random mix.
    for (int it = 0; it < 400; it++) begin
      int nw = $urandom_range(0, 4);
      for (int k = 0; k < nw; k++) begin
        int sel = $urandom_range(0, 20);
        logic [4:0] a = (sel == 20) ? 5'd17 : (sel == 19) ? 5'($urandom_range(18, 31)) : 5'(sel);
        logic [3:0] d = (a == 5'd17) ? (($urandom_range(0, 9) == 0) ? 4'h0 : 4'h1) : 4'($urandom);
        wr(a, d);
      end
      step_check("R6 R7 R8 random", 17'($urandom) & 17'($urandom), 4'($urandom_range(0, 15)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule